// File: doc/BRIEF.md
# Infrared Beam-Break Burst Generator

This block drives an infrared emitter for beam-break sensing, where the receiver is a demodulating module tuned to a 38 kHz carrier. The generator sends a frame made of a fixed number of carrier bursts. Each burst is followed by a silent gap of the same length. After the last gap, a long pause passes, and then the next frame begins.

The carrier appears on two outputs in antiphase, so the emitter can be driven push-pull across two pins. When no carrier is being sent, output A rests high and output B rests low. A one-clock strobe marks the start of every frame. All timing values are worked out from parameters: the clock frequency, the carrier frequency, the number of carrier cycles per burst, the number of bursts per frame and the pause length in microseconds.

Top module: `ir_burst_gen`

## Requirements
- R1: The carrier half-period in clocks is CLK_HZ / (2 * CARRIER_HZ), rounded to the nearest integer with halves rounded up. With the defaults (9.6 MHz clock, 38 kHz carrier) this is 126 clocks.
- R2: A burst is exactly CYCLES_PER_BURST full carrier cycles, with no truncated half-period at either end. In the first half of each cycle, drv_a_o is 1 and drv_b_o is 0. In the second half the two outputs swap. Each half lasts exactly one half-period.
- R3: Each burst is followed by a gap of exactly 2 * CYCLES_PER_BURST half-periods. During the gap, drv_a_o is 1 and drv_b_o is 0.
- R4: A frame is BURSTS_PER_FRAME burst-plus-gap pairs, then a pause of PAUSE_CLKS clocks with idle outputs. The next frame starts on the clock after the pause ends.
- R5: frame_start_o is 1 for exactly one clock, the first clock of burst 0 of every frame. It is 0 at every other time.
- R6: While en_i is low, the outputs hold the idle state (drv_a_o=1, drv_b_o=0, frame_start_o=0) from the next clock on, and all progress is cleared. A later enable restarts the frame from burst 0.
- R7: If en_i is sampled high at an edge after being low, the first burst of a frame starts on the clock that follows that edge.
- R8: While rst_ni is low, drv_a_o=1, drv_b_o=0 and frame_start_o=0.
- R9: PAUSE_CLKS = CLK_HZ * PAUSE_US / 1,000,000, rounded down. The default of 25000 us gives 240000 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; when low, the generator is held idle |
| drv_a_o | output | 1 | Emitter drive A; rests high |
| drv_b_o | output | 1 | Emitter drive B, in antiphase with A during bursts; rests low |
| frame_start_o | output | 1 | One-clock pulse on the first clock of each frame |

## Verification
All outputs are decoded from registered state, so each takes effect one clock after the edge that samples the stimulus. If en_i is raised before edge k, frame_start_o and the first high half of the carrier appear in the cycle after edge k. If en_i is dropped, the idle levels appear one edge later. The bench drives inputs on falling edges. At each falling edge it counts the clocks since the enabling edge and compares all three outputs against a reference computed from frame position: half-period, burst, gap and pause lengths. That way every carrier edge, gap boundary and pause boundary is checked in the exact cycle it is due.

// File: rtl/ir_burst_pkg.sv
package ir_burst_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_BURST = 2'd1,
    PH_GAP   = 2'd2,
    PH_PAUSE = 2'd3
  } phase_e;

  // Nearest-integer half-period (R1)
  function automatic int unsigned half_clks(longint unsigned clk_hz, longint unsigned car_hz);
    return int'((clk_hz + car_hz) / (2 * car_hz));
  endfunction

  // Floor of clk_hz * us / 1e6 (R9)
  function automatic int unsigned us_to_clks(longint unsigned clk_hz, longint unsigned us);
    return int'((clk_hz * us) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/ir_half_timer.sv
module ir_half_timer #(
  parameter int unsigned HALF_CLKS = 126
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o,
  output logic first_o
);
  localparam int unsigned W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [W-1:0] LAST = W'(HALF_CLKS - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o  = run_i && (cnt_q == LAST);
  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/ir_wrap_cnt.sv
module ir_wrap_cnt #(
  parameter int unsigned LIMIT = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic zero_o,
  output logic odd_o,
  output logic last_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign odd_o  = cnt_q[0];
  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/ir_burst_seq.sv
module ir_burst_seq
  import ir_burst_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   half_tick_i,
  input  logic   half_last_i,
  input  logic   burst_last_i,
  input  logic   pause_last_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!en_i) begin
      phase_d = PH_OFF;
    end else begin
      unique case (phase_q)
        PH_OFF:   phase_d = PH_BURST;
        PH_BURST: if (half_tick_i && half_last_i) phase_d = PH_GAP;
        PH_GAP:   if (half_tick_i && half_last_i)
                    phase_d = burst_last_i ? PH_PAUSE : PH_BURST;
        PH_PAUSE: if (pause_last_i) phase_d = PH_BURST;
        default:  phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_OFF;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/ir_burst_gen.sv
module ir_burst_gen
  import ir_burst_pkg::*;
#(
  parameter int unsigned CLK_HZ           = 9_600_000,
  parameter int unsigned CARRIER_HZ       = 38_000,
  parameter int unsigned CYCLES_PER_BURST = 30,
  parameter int unsigned BURSTS_PER_FRAME = 20,
  parameter int unsigned PAUSE_US         = 25_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic drv_a_o,
  output logic drv_b_o,
  output logic frame_start_o
);
  localparam int unsigned HALF_CLKS  = half_clks(CLK_HZ, CARRIER_HZ);
  localparam int unsigned HALVES     = 2 * CYCLES_PER_BURST;
  localparam int unsigned PAUSE_RAW  = us_to_clks(CLK_HZ, PAUSE_US);
  localparam int unsigned PAUSE_CLKS = (PAUSE_RAW > 0) ? PAUSE_RAW : 1;

  phase_e phase;
  logic   running, in_burst;
  logic   half_tick, half_first;
  logic   half_zero, half_odd, half_last;
  logic   burst_zero, burst_odd, burst_last;
  logic   pause_zero, pause_odd, pause_last;

  assign running  = en_i && (phase == PH_BURST || phase == PH_GAP);
  assign in_burst = (phase == PH_BURST);

  ir_half_timer #(.HALF_CLKS(HALF_CLKS)) u_half (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (running),
    .tick_o  (half_tick),
    .first_o (half_first)
  );

  // Half-period index within a burst or gap
  ir_wrap_cnt #(.LIMIT(HALVES)) u_halves (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!running),
    .inc_i  (half_tick),
    .zero_o (half_zero),
    .odd_o  (half_odd),
    .last_o (half_last)
  );

  // Burst index within a frame
  ir_wrap_cnt #(.LIMIT(BURSTS_PER_FRAME)) u_bursts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!en_i || phase == PH_OFF),
    .inc_i  (phase == PH_GAP && half_tick && half_last),
    .zero_o (burst_zero),
    .odd_o  (burst_odd),
    .last_o (burst_last)
  );

  ir_wrap_cnt #(.LIMIT(PAUSE_CLKS)) u_pause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!en_i || phase != PH_PAUSE),
    .inc_i  (phase == PH_PAUSE),
    .zero_o (pause_zero),
    .odd_o  (pause_odd),
    .last_o (pause_last)
  );

  ir_burst_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .half_tick_i  (half_tick),
    .half_last_i  (half_last),
    .burst_last_i (burst_last),
    .pause_last_i (pause_last),
    .phase_o      (phase)
  );

  // Idle level: A high, B low; carrier even halves match idle
  assign drv_a_o       = !in_burst || !half_odd;
  assign drv_b_o       = in_burst && half_odd;
  assign frame_start_o = in_burst && burst_zero && half_zero && half_first;
endmodule

// File: rtl/ir_burst_gen_chk.sv
module ir_burst_gen_chk #(
  parameter int unsigned HALF_CLKS = 126
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic drv_a_o,
  input logic drv_b_o,
  input logic frame_start_o
);
  logic [31:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_run_q <= '0;
    else if (drv_a_o) low_run_q <= '0;
    else if (low_run_q != 32'hFFFF_FFFF) low_run_q <= low_run_q + 1;
  end

  // R2: a low half of A lasts exactly one half-period when not cut by disable
  a_r2_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(drv_a_o) && $past(en_i)) |-> (low_run_q == HALF_CLKS));

  // R2: drives never high together
  a_r2_antiphase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_a_o && drv_b_o));

  // R5: strobe is a single clock, aligned with A high
  a_r5_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  a_r5_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (drv_a_o && !drv_b_o));

  // R6: disabled means idle next clock
  a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (drv_a_o && !drv_b_o && !frame_start_o));

  // R7: enable rise starts a frame on the following clock
  a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i ##1 en_i) |=> frame_start_o);

  // R8: reset levels
  always @(negedge clk_i)
    if (!rst_ni) a_r8_reset: assert (drv_a_o && !drv_b_o && !frame_start_o);
endmodule

bind ir_burst_gen ir_burst_gen_chk #(.HALF_CLKS(HALF_CLKS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .drv_a_o       (drv_a_o),
  .drv_b_o       (drv_b_o),
  .frame_start_o (frame_start_o)
);

// File: tb/ir_burst_gen_tb_top.sv
`timescale 1ns/1ps
module ir_burst_gen_tb_top;
  localparam int unsigned CLK_HZ = 430_000;
  localparam int unsigned CAR_HZ = 50_000;
  localparam int unsigned CYC    = 3;
  localparam int unsigned NB     = 2;
  localparam int unsigned P_US   = 50;
  // Hand-computed from R1 and R9: 4.3 rounds to 4, 21.5 floors to 21
  localparam int HALF   = 4;
  localparam int PAUSE  = 21;
  localparam int BURST  = 2 * CYC * HALF;
  localparam int PAIR   = 2 * BURST;
  localparam int FRAME  = NB * PAIR + PAUSE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic a, b, s;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ir_burst_gen #(
    .CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ), .CYCLES_PER_BURST(CYC),
    .BURSTS_PER_FRAME(NB), .PAUSE_US(P_US)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .drv_a_o(a), .drv_b_o(b), .frame_start_o(s)
  );

  task automatic chk(string req, logic [2:0] got, logic [2:0] exp, int t);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0d {a,b,strobe} actual=%b expected=%b", req, t, got, exp);
    end
  endtask

  // Reference {a,b,strobe} at clock t counted from first burst clock
  function automatic logic [2:0] ref_out(int t);
    int p = t % FRAME;
    int q;
    if (p >= NB * PAIR) return 3'b100;
    q = p % PAIR;
    if (q >= BURST) return 3'b100;
    if (((q / HALF) % 2) == 0) return {2'b10, p == 0};
    return 3'b010;
  endfunction

  function automatic string tag(int t);
    int p = t % FRAME;
    if (p == 0) return "R5";
    if (p >= NB * PAIR) return "R4";
    if ((p % PAIR) >= BURST) return "R3";
    return (t < HALF) ? "R1" : "R2";
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R8", {a, b, s}, 3'b100, -1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", {a, b, s}, 3'b100, -1);
  endtask

  // Enable and follow n clocks against the reference (R7 start timing)
  task automatic t_run(int n);
    en = 1'b1;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      chk(t == 0 ? "R7" : tag(t), {a, b, s}, ref_out(t), t);
    end
  endtask

  task automatic t_disable(int hold);
    en = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6", {a, b, s}, 3'b100, i);
    end
  endtask

  initial begin
    t_reset();
    t_disable(5);
    t_run(3 * FRAME + 5);           // three frames plus restart: R1..R5, R9
    t_disable(3);
    t_run(BURST + HALF + 2);        // R6: restart cut mid-gap
    t_disable(1);
    t_run(HALF + 1);                // R6: cut during second half, restart at burst 0
    t_disable(2);
    t_run(NB * PAIR + PAUSE + 2);   // R6/R7: full frame after re-enable
    t_disable(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule